// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog with Management Interrupt

This block is a countdown watchdog for a system that gives firmware one chance to recover before the hardware is reset. When the counter runs out the first time, the block sets a sticky timeout flag and may raise a system-management interrupt (SMI) request. The counter then reloads and keeps counting. If it runs out again before software reloads it, the block issues a one-cycle reset request and returns to its power-on state. A hung system is therefore reset after roughly two timeout periods.

Software uses four word registers, selected by a 2-bit address. Address 0 holds the reload value. Address 1 is control. Address 2 is status. Writing to address 3 kicks the timer, and reading address 3 returns the live count. The SMI request is gated at two levels: a timer-specific enable and a global enable. The time base comes from outside through a tick-enable input, so the counter moves only on cycles where that input is high.

Top module: `two_stage_wdt`

## Requirements
- R1: After rst_ni is released, the registers read as follows: control reads 0x800 (halted, both SMI enables off), status reads 0, the count and the reload value equal RELOAD_DEF (255 by default), and smi_o and rst_req_o are low.
- R2: While control bit 11 (halt) is 0, the count drops by one on each clock edge that samples tick_i high. While halt is 1, or while tick_i is low, the count holds.
- R3: The first expiry happens on a tick edge that finds the count at 0 with the stage flag clear. At that edge the block sets status bit 0 (timeout), sets status bit 1 (stage) and reloads the count from the reload register. It does not request a reset.
- R4: A tick edge that finds the count at 0 with the stage flag set is the second expiry. It drives rst_req_o high for exactly one cycle. The same edge returns every register to its R1 value.
- R5: Writing status with bit 0 set clears the timeout flag. Writing 0 there leaves the flag set. Clearing the flag changes neither the count nor the stage flag, so the next expiry still resets the system.
- R6: Any write to address 3 loads the count from the reload register and clears the stage flag, but leaves the timeout flag as it is. If a kick and a tick fall on the same edge, the kick wins.
- R7: Writing the reload register (address 0) does not change the running count. The new value takes effect at the next kick or expiry.
- R8: smi_o is high exactly while the timeout flag, control bit 13 (timer SMI enable) and control bit 0 (global SMI enable) are all 1.
- R9: Starting from a kick with reload value N and timeout cleared, ticking continuously makes rst_req_o rise on tick number 2*(N+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable; one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| smi_o | output | 1 | Management interrupt request, level |
| rst_req_o | output | 1 | System reset request, one-cycle pulse |

## Verification
The assertions check the following on every cycle:
- the reset request is one cycle wide;
- a reset request is preceded by an armed stage and leaves all state cleared;
- a halted counter holds its value;
- the timeout flag stays set until a write-one-to-clear or a reset;
- a kick reloads the count and disarms the stage;
- SMI stays off while the global enable is off.

Only the directed scenarios show:
- the exact tick on which each expiry lands;
- that clearing the timeout flag does not rescue the system;
- kick-over-tick priority;
- the 2*(N+1) tick window from kick to reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_RELOAD = 2'd0,
    A_CTRL   = 2'd1,
    A_STAT   = 2'd2,
    A_KICK   = 2'd3
  } wdt_addr_e;

  // control bit positions
  localparam int GBL_BIT  = 0;
  localparam int HALT_BIT = 11;
  localparam int TSMI_BIT = 13;
  // status bit positions
  localparam int TO_BIT   = 0;
  localparam int STG_BIT  = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD_DEF = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_to_i,
  input  logic              soft_clr_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              gbl_en_o,
  output logic              tsmi_en_o,
  output logic              halt_o,
  output logic              timeout_o,
  output logic              kick_o
);
  logic wr_reload, wr_ctrl, wr_stat;
  logic unused_wdata;

  assign wr_reload    = wr_en_i && (addr_i == A_RELOAD);
  assign wr_ctrl      = wr_en_i && (addr_i == A_CTRL);
  assign wr_stat      = wr_en_i && (addr_i == A_STAT);
  assign kick_o       = wr_en_i && (addr_i == A_KICK);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o  <= RELOAD_DEF;
      gbl_en_o  <= 1'b0;
      tsmi_en_o <= 1'b0;
      halt_o    <= 1'b1;
      timeout_o <= 1'b0;
    end else if (soft_clr_i) begin
      reload_o  <= RELOAD_DEF;
      gbl_en_o  <= 1'b0;
      tsmi_en_o <= 1'b0;
      halt_o    <= 1'b1;
      timeout_o <= 1'b0;
    end else begin
      if (wr_reload) reload_o <= wdata_i[CNT_W-1:0];
      if (wr_ctrl) begin
        gbl_en_o  <= wdata_i[GBL_BIT];
        tsmi_en_o <= wdata_i[TSMI_BIT];
        halt_o    <= wdata_i[HALT_BIT];
      end
      // set beats clear
      if (set_to_i)                         timeout_o <= 1'b1;
      else if (wr_stat && wdata_i[TO_BIT]) timeout_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RELOAD_DEF = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             stage_o,
  output logic             first_exp_o,
  output logic             second_exp_o
);
  logic step, at_zero;

  assign step         = tick_i && !halt_i && !kick_i;
  assign at_zero      = (count_o == '0);
  assign first_exp_o  = step && at_zero && !stage_o;
  assign second_exp_o = step && at_zero && stage_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= RELOAD_DEF;
      stage_o <= 1'b0;
    end else if (second_exp_o) begin
      count_o <= RELOAD_DEF;
      stage_o <= 1'b0;
    end else if (kick_i) begin
      count_o <= reload_i;
      stage_o <= 1'b0;
    end else if (first_exp_o) begin
      count_o <= reload_i;
      stage_o <= 1'b1;
    end else if (step) begin
      count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD_DEF = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              smi_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] reload, count;
  logic gbl_en, tsmi_en, halt, timeout, kick;
  logic stage, first_exp, second_exp;

  wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RELOAD_DEF(RELOAD_DEF)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .set_to_i(first_exp), .soft_clr_i(second_exp),
    .reload_o(reload), .gbl_en_o(gbl_en), .tsmi_en_o(tsmi_en),
    .halt_o(halt), .timeout_o(timeout), .kick_o(kick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_DEF(RELOAD_DEF)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .halt_i(halt),
    .kick_i(kick), .reload_i(reload), .count_o(count), .stage_o(stage),
    .first_exp_o(first_exp), .second_exp_o(second_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_o <= 1'b0;
    else         rst_req_o <= second_exp;
  end

  assign smi_o = timeout && tsmi_en && gbl_en;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RELOAD: rdata_o[CNT_W-1:0] = reload;
      A_CTRL: begin
        rdata_o[GBL_BIT]  = gbl_en;
        rdata_o[HALT_BIT] = halt;
        rdata_o[TSMI_BIT] = tsmi_en;
      end
      A_STAT: begin
        rdata_o[TO_BIT]  = timeout;
        rdata_o[STG_BIT] = stage;
      end
      default: rdata_o[CNT_W-1:0] = count;
    endcase
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              stage,
  input logic              halt,
  input logic              kick,
  input logic              timeout,
  input logic              gbl_en,
  input logic              tsmi_en,
  input logic              second_exp,
  input logic              smi_o,
  input logic              rst_req_o
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (addr_i == A_STAT) && wdata_i[TO_BIT];

  // R4
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R4
  rst_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (halt && !timeout && !stage && !gbl_en && !tsmi_en));

  // R3
  rst_needs_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(stage));

  // R2
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !kick) |=> $stable(count));

  // R5
  to_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout && !clr_wr && !second_exp) |=> timeout);

  // R6
  kick_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> (!stage && (count == $past(reload))));

  // R8
  smi_gbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gbl_en |-> !smi_o);
endmodule

bind two_stage_wdt wdt_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .count(count), .reload(reload), .stage(stage),
  .halt(halt), .kick(kick), .timeout(timeout), .gbl_en(gbl_en),
  .tsmi_en(tsmi_en), .second_exp(second_exp), .smi_o(smi_o),
  .rst_req_o(rst_req_o)
);

// File: tb/two_stage_wdt_tb.sv
`timescale 1ns/1ps
module two_stage_wdt_tb;
  localparam logic [1:0] A_RLD = 2'd0, A_CTL = 2'd1, A_STS = 2'd2, A_KCK = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        smi, rst_req;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  two_stage_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .smi_o(smi),
    .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTL, v); chk("R1 ctrl", v, 32'h800);
    rd(A_KCK, v); chk("R1 count", v, 32'd255);
    rd(A_RLD, v); chk("R1 reload", v, 32'd255);
    rd(A_STS, v); chk("R1 status", v, 32'd0);
    chk("R1 smi", {31'd0, smi}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    ticks(5);
    rd(A_KCK, v); chk("R2 halted count", v, 32'd255);
    wr(A_RLD, 32'd3);
    wr(A_KCK, 32'd0);
    rd(A_KCK, v); chk("R6 kick loads", v, 32'd3);
    wr(A_CTL, 32'd0);
    ticks(2);
    rd(A_KCK, v); chk("R2 decrement", v, 32'd1);
    repeat (3) @(negedge clk);
    rd(A_KCK, v); chk("R2 no tick hold", v, 32'd1);
  endtask

  task automatic t_first;
    logic [31:0] v;
    ticks(1);
    rd(A_KCK, v); chk("R3 reach zero", v, 32'd0);
    rd(A_STS, v); chk("R3 no flag at zero", v, 32'd0);
    ticks(1);
    rd(A_STS, v); chk("R3 status", v, 32'd3);
    rd(A_KCK, v); chk("R3 reload", v, 32'd3);
    chk("R3 no reset", {31'd0, rst_req}, 32'd0);
    chk("R8 smi off", {31'd0, smi}, 32'd0);
  endtask

  task automatic t_smi;
    wr(A_CTL, 32'h2000);
    chk("R8 timer en only", {31'd0, smi}, 32'd0);
    wr(A_CTL, 32'h0001);
    chk("R8 global only", {31'd0, smi}, 32'd0);
    wr(A_CTL, 32'h2001);
    chk("R8 both", {31'd0, smi}, 32'd1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(A_STS, 32'd0);
    rd(A_STS, v); chk("R5 write zero keeps", v, 32'd3);
    wr(A_STS, 32'd1);
    rd(A_STS, v); chk("R5 w1c", v, 32'd2);
    chk("R5 smi drops", {31'd0, smi}, 32'd0);
    rd(A_KCK, v); chk("R5 count kept", v, 32'd3);
    ticks(3);
    chk("R5 no early reset", {31'd0, rst_req}, 32'd0);
    ticks(1);
    chk("R4 reset pulse", {31'd0, rst_req}, 32'd1);
    rd(A_CTL, v); chk("R4 ctrl back", v, 32'h800);
    rd(A_KCK, v); chk("R4 count back", v, 32'd255);
    rd(A_STS, v); chk("R4 status back", v, 32'd0);
    rd(A_RLD, v); chk("R4 reload back", v, 32'd255);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'd0, rst_req}, 32'd0);
  endtask

  task automatic t_kick;
    logic [31:0] v;
    wr(A_RLD, 32'd2);
    wr(A_KCK, 32'd0);
    wr(A_CTL, 32'h2001);
    ticks(3);
    rd(A_STS, v); chk("R3 expiry", v, 32'd3);
    ticks(1);
    wr(A_KCK, 32'd0);
    rd(A_KCK, v); chk("R6 kick count", v, 32'd2);
    rd(A_STS, v); chk("R6 stage cleared, timeout kept", v, 32'd1);
    ticks(3);
    chk("R6 re-expiry no reset", {31'd0, rst_req}, 32'd0);
    rd(A_STS, v); chk("R6 first again", v, 32'd3);
    ticks(1);
    tick = 1'b1;
    wr(A_KCK, 32'd0);
    tick = 1'b0;
    rd(A_KCK, v); chk("R6 kick beats tick", v, 32'd2);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(A_RLD, 32'd5);
    rd(A_KCK, v); chk("R7 count unchanged", v, 32'd2);
    wr(A_KCK, 32'd0);
    rd(A_KCK, v); chk("R7 applied at kick", v, 32'd5);
  endtask

  task automatic t_window;
    int n = 0;
    wr(A_STS, 32'd1);
    wr(A_KCK, 32'd0);
    for (int i = 0; i < 30 && !rst_req; i++) begin
      ticks(1);
      n++;
    end
    chk("R9 ticks to reset", n, 32'd12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_first;
    t_smi;
    t_clear;
    t_kick;
    t_reload;
    t_window;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule